// File: doc/BRIEF.md
# Multi-Warp Issue Scheduler

This block keeps the issue state for the warps resident in one processing partition. Up to sixteen warps can be resident. In each cycle it picks at most one eligible warp and sends that warp's pending instruction to a narrow group of execution lanes. A warp is eligible when its valid and ready bits are both set and it is not waiting on memory. Every warp has 32 threads. A warp instruction is therefore cut into lane slices and sent over consecutive cycles: two slices of 16 lanes for single-precision work and loads, and four slices of 8 lanes for double-precision work. The selected warp is held until its last slice has gone out.

A warp whose load has been dispatched is marked as waiting and is skipped. Other ready warps keep the issue slot busy in the meantime, which hides the memory latency. A completion pulse that carries a warp number clears that warp's waiting mark. Fetch, decode, operand storage and the arithmetic units sit outside this block. The block only delivers a strobe, a warp number, a slice index and a lane mask each cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, `issue_strobe` is 0 and `issue_lane_mask` is 0. Reset clears all waiting marks. The first search after reset starts at warp 0.
- R2: A warp is eligible when its `warp_valid` bit and `warp_ready` bit are both 1 and it is not waiting. Inputs sampled at a rising edge decide the outputs shown after that edge. At most one warp is issued per cycle.
- R3: The class of warp i is `warp_class[2i+1:2i]`. Code 0 is single precision: 2 slices, mask 16'hFFFF. Code 1 is double precision: 4 slices, mask 16'h00FF. Code 2 is a load: 2 slices, mask 16'hFFFF. Code 3 behaves like code 0.
- R4: Once a warp is issued, its slices come out in consecutive cycles with indices 0, 1, … up to the last slice, all with the same warp number. No other warp is picked until the last slice is out. A new warp may be issued in the very next cycle after that.
- R5: The search for a new warp starts at the warp after the one most recently issued and wraps from the highest warp number to 0.
- R6: When no warp is eligible, `issue_strobe` and `issue_lane_mask` are 0 and the round-robin position is left unchanged.
- R7: A warp whose load has sent its last slice becomes waiting. It is not issued again until a completion arrives for it.
- R8: A `mem_done` pulse with `mem_done_id` = w clears warp w's waiting mark, so w can be issued two cycles after the pulse is applied. If the pulse coincides with w's final load slice, the completion wins and w may be issued in the next cycle.
- R9: Changes to a warp's valid, ready or class inputs while its dispatch is in progress do not alter the remaining slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_valid | input | NUM_WARPS | Warp holds a pending instruction |
| warp_ready | input | NUM_WARPS | Warp operands are ready |
| warp_class | input | 2*NUM_WARPS | Per-warp instruction class code |
| mem_done | input | 1 | Memory completion pulse |
| mem_done_id | input | clog2(NUM_WARPS) | Warp that the completion belongs to |
| issue_strobe | output | 1 | A slice is being issued this cycle |
| issue_warp | output | clog2(NUM_WARPS) | Warp being issued |
| issue_slice | output | clog2(max slices) | Index of the slice being issued |
| issue_lane_mask | output | FP32_LANES | Lanes enabled for this slice |

## Verification
The bench builds the block with its default parameters: 16 warps, 32 threads, a 16-lane single-precision group and an 8-lane double-precision group. With these values every wrap of the round-robin search and both slice counts are reachable in a short run. Directed phases walk the pointer through all sixteen warps and run a four-slice dispatch on a lone warp. They also cover an idle stretch that must leave the pointer unchanged, a stalled load with both late and same-edge completions, and input changes in the middle of a dispatch. A long pseudo-random phase then drives every input at random and compares each cycle with an arithmetic model kept in the bench.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic [1:0] {
        CLS_FP32  = 2'd0,
        CLS_FP64  = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_SPARE = 2'd3
    } iclass_e;

    // lanes consumed per cycle by a class
    function automatic int lanes_for(input iclass_e cls, input int l32, input int l64);
        return (cls == CLS_FP64) ? l64 : l32;
    endfunction

    // index of the final slice for a class
    function automatic int last_slice_for(input iclass_e cls, input int threads,
                                          input int l32, input int l64);
        int l;
        l = lanes_for(cls, l32, l64);
        return (threads + l - 1) / l - 1;
    endfunction

endpackage

// File: rtl/wis_wait_tracker.sv
module wis_wait_tracker #(
    parameter int NUM_WARPS = 16,
    localparam int IDW = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [IDW-1:0]       set_id,
    input  logic                 clr_en,
    input  logic [IDW-1:0]       clr_id,
    output logic [NUM_WARPS-1:0] waiting
);
    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                waiting[i] <= 1'b0;
            end else if (clr_en && clr_id == IDW'(i)) begin
                waiting[i] <= 1'b0;   // completion has priority
            end else if (set_en && set_id == IDW'(i)) begin
                waiting[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter #(
    parameter int NUM_WARPS = 16,
    localparam int IDW = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] req,
    input  logic [IDW-1:0]       last_id,
    output logic                 gnt_valid,
    output logic [IDW-1:0]       gnt_id
);
    int c;
    always_comb begin
        gnt_valid = 1'b0;
        gnt_id    = '0;
        c         = 0;
        for (int i = 1; i <= NUM_WARPS; i++) begin
            c = int'(last_id) + i;
            if (c >= NUM_WARPS) c = c - NUM_WARPS;
            if (!gnt_valid && req[IDW'(c)]) begin
                gnt_valid = 1'b1;
                gnt_id    = IDW'(c);
            end
        end
    end
endmodule

// File: rtl/wis_slice_seq.sv
module wis_slice_seq
    import wis_pkg::*;
#(
    parameter int NUM_WARPS    = 16,
    parameter int WARP_THREADS = 32,
    parameter int FP32_LANES   = 16,
    parameter int FP64_LANES   = 8,
    localparam int IDW = $clog2(NUM_WARPS),
    localparam int MAX_SLICES = (WARP_THREADS + FP64_LANES - 1) / FP64_LANES,
    localparam int SLW = (MAX_SLICES > 1) ? $clog2(MAX_SLICES) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [IDW-1:0] start_warp,
    input  iclass_e        start_cls,
    output logic           strobe_o,
    output logic [IDW-1:0] warp_o,
    output logic [SLW-1:0] slice_o,
    output iclass_e        cls_o,
    output logic           busy_o,
    output logic           final_now_o,
    output logic [IDW-1:0] emit_warp_o,
    output iclass_e        emit_cls_o
);
    logic [SLW-1:0] last_q;
    logic [SLW-1:0] start_last;

    assign start_last = SLW'(last_slice_for(start_cls, WARP_THREADS, FP32_LANES, FP64_LANES));

    // the slice leaving at the coming edge is the final one
    always_comb begin
        if (busy_o) begin
            final_now_o = (slice_o + SLW'(1)) == last_q;
            emit_warp_o = warp_o;
            emit_cls_o  = cls_o;
        end else begin
            final_now_o = start && (start_last == '0);
            emit_warp_o = start_warp;
            emit_cls_o  = start_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_o <= 1'b0;
            busy_o   <= 1'b0;
            warp_o   <= '0;
            slice_o  <= '0;
            last_q   <= '0;
            cls_o    <= CLS_FP32;
        end else if (busy_o) begin
            strobe_o <= 1'b1;
            slice_o  <= slice_o + SLW'(1);
            busy_o   <= !final_now_o;
        end else if (start) begin
            strobe_o <= 1'b1;
            warp_o   <= start_warp;
            cls_o    <= start_cls;
            slice_o  <= '0;
            last_q   <= start_last;
            busy_o   <= (start_last != '0);
        end else begin
            strobe_o <= 1'b0;
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS    = 16,
    parameter int WARP_THREADS = 32,
    parameter int FP32_LANES   = 16,
    parameter int FP64_LANES   = 8,
    localparam int IDW = $clog2(NUM_WARPS),
    localparam int MAX_SLICES = (WARP_THREADS + FP64_LANES - 1) / FP64_LANES,
    localparam int SLW = (MAX_SLICES > 1) ? $clog2(MAX_SLICES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_WARPS-1:0]   warp_valid,
    input  logic [NUM_WARPS-1:0]   warp_ready,
    input  logic [2*NUM_WARPS-1:0] warp_class,
    input  logic                   mem_done,
    input  logic [IDW-1:0]         mem_done_id,
    output logic                   issue_strobe,
    output logic [IDW-1:0]         issue_warp,
    output logic [SLW-1:0]         issue_slice,
    output logic [FP32_LANES-1:0]  issue_lane_mask
);
    logic [NUM_WARPS-1:0] waiting;
    logic [NUM_WARPS-1:0] eligible;
    logic                 gnt_valid;
    logic [IDW-1:0]       gnt_id;
    logic [IDW-1:0]       rr_q;
    logic                 busy;
    logic                 start;
    logic                 final_now;
    logic [IDW-1:0]       emit_warp;
    iclass_e              emit_cls;
    iclass_e              start_cls;
    iclass_e              cur_cls;

    assign eligible  = warp_valid & warp_ready & ~waiting;
    assign start     = !busy && gnt_valid;
    assign start_cls = iclass_e'(warp_class[2*gnt_id +: 2]);

    wis_rr_arbiter #(.NUM_WARPS(NUM_WARPS)) u_arb (
        .req       (eligible),
        .last_id   (rr_q),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id)
    );

    always_ff @(posedge clk) begin
        if (rst)        rr_q <= IDW'(NUM_WARPS - 1);
        else if (start) rr_q <= gnt_id;
    end

    wis_slice_seq #(
        .NUM_WARPS    (NUM_WARPS),
        .WARP_THREADS (WARP_THREADS),
        .FP32_LANES   (FP32_LANES),
        .FP64_LANES   (FP64_LANES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_warp  (gnt_id),
        .start_cls   (start_cls),
        .strobe_o    (issue_strobe),
        .warp_o      (issue_warp),
        .slice_o     (issue_slice),
        .cls_o       (cur_cls),
        .busy_o      (busy),
        .final_now_o (final_now),
        .emit_warp_o (emit_warp),
        .emit_cls_o  (emit_cls)
    );

    wis_wait_tracker #(.NUM_WARPS(NUM_WARPS)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .set_en  (final_now && emit_cls == CLS_LOAD),
        .set_id  (emit_warp),
        .clr_en  (mem_done),
        .clr_id  (mem_done_id),
        .waiting (waiting)
    );

    always_comb begin
        issue_lane_mask = '0;
        if (issue_strobe) begin
            for (int l = 0; l < FP32_LANES; l++) begin
                if (l < lanes_for(cur_cls, FP32_LANES, FP64_LANES)) issue_lane_mask[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
    parameter int NUM_WARPS    = 16,
    parameter int WARP_THREADS = 32,
    parameter int FP32_LANES   = 16,
    parameter int FP64_LANES   = 8,
    localparam int IDW = $clog2(NUM_WARPS),
    localparam int MAX_SLICES = (WARP_THREADS + FP64_LANES - 1) / FP64_LANES,
    localparam int SLW = (MAX_SLICES > 1) ? $clog2(MAX_SLICES) : 1,
    localparam int N32 = (WARP_THREADS + FP32_LANES - 1) / FP32_LANES
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_WARPS-1:0]   warp_valid,
    input logic [NUM_WARPS-1:0]   warp_ready,
    input logic [2*NUM_WARPS-1:0] warp_class,
    input logic                   mem_done,
    input logic [IDW-1:0]         mem_done_id,
    input logic                   issue_strobe,
    input logic [IDW-1:0]         issue_warp,
    input logic [SLW-1:0]         issue_slice,
    input logic [FP32_LANES-1:0]  issue_lane_mask
);
    localparam logic [FP32_LANES-1:0] FULL = {FP32_LANES{1'b1}};
    localparam logic [FP32_LANES-1:0] NARROW = FP32_LANES'((64'd1 << FP64_LANES) - 64'd1);

    logic [NUM_WARPS-1:0] ready_seen_q;
    always_ff @(posedge clk) ready_seen_q <= warp_valid & warp_ready;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!issue_strobe && issue_lane_mask == '0));

    p_pick_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_strobe && issue_slice == '0) |-> ready_seen_q[issue_warp]);

    p_mask_shape_r3: assert property (@(posedge clk) disable iff (rst)
        issue_strobe |-> (issue_lane_mask == FULL || issue_lane_mask == NARROW));

    p_wide_tail_r3: assert property (@(posedge clk) disable iff (rst)
        (issue_strobe && int'(issue_slice) >= N32) |-> issue_lane_mask == NARROW);

    p_slice_chain_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_strobe && issue_slice != '0) |->
            ($past(issue_strobe) && issue_warp == $past(issue_warp)
             && issue_slice == $past(issue_slice) + SLW'(1)
             && issue_lane_mask == $past(issue_lane_mask)));

    p_idle_mask_r6: assert property (@(posedge clk) disable iff (rst)
        !issue_strobe |-> issue_lane_mask == '0);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
    .NUM_WARPS    (NUM_WARPS),
    .WARP_THREADS (WARP_THREADS),
    .FP32_LANES   (FP32_LANES),
    .FP64_LANES   (FP64_LANES)
) u_chk (.*);

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;
    localparam int IDW = 4;
    localparam int SLW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NW-1:0]   valid = '0;
    logic [NW-1:0]   ready = '0;
    logic [2*NW-1:0] cls = '0;
    logic            mdone = 1'b0;
    logic [IDW-1:0]  mid = '0;
    logic            strobe;
    logic [IDW-1:0]  warp;
    logic [SLW-1:0]  slice;
    logic [15:0]     mask;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_issue_sched u_warp_issue_sched (
        .clk(clk), .rst(rst), .warp_valid(valid), .warp_ready(ready),
        .warp_class(cls), .mem_done(mdone), .mem_done_id(mid),
        .issue_strobe(strobe), .issue_warp(warp), .issue_slice(slice),
        .issue_lane_mask(mask)
    );

    // bench model state
    bit       m_busy, m_strobe;
    int       m_warp, m_slice, m_last, m_cls, m_rr;
    bit [NW-1:0] m_wait;

    function automatic int nslices(input int c);
        return (c == 1) ? 4 : 2;   // 32 threads over 8 or 16 lanes
    endfunction

    task automatic model_reset();
        m_busy = 0; m_strobe = 0; m_warp = 0; m_slice = 0; m_last = 0;
        m_cls = 0; m_rr = NW - 1; m_wait = '0;
    endtask

    task automatic model_tick();
        bit set_w; int set_id;
        set_w = 0; set_id = 0;
        if (m_busy) begin
            m_slice++;
            m_strobe = 1;
            if (m_slice == m_last) begin
                m_busy = 0;
                if (m_cls == 2) begin set_w = 1; set_id = m_warp; end
            end
        end else begin
            m_strobe = 0;
            for (int j = 1; j <= NW; j++) begin
                int w;
                w = (m_rr + j) % NW;
                if (!m_strobe && valid[w] && ready[w] && !m_wait[w]) begin
                    m_strobe = 1; m_warp = w; m_rr = w; m_slice = 0;
                    m_cls = int'(cls[2*w +: 2]);
                    m_last = nslices(m_cls) - 1;
                    m_busy = 1;
                end
            end
        end
        if (set_w) m_wait[set_id] = 1'b1;
        if (mdone) m_wait[mid] = 1'b0;
    endtask

    function automatic logic [15:0] model_mask();
        if (!m_strobe) return 16'h0000;
        return (m_cls == 1) ? 16'h00FF : 16'hFFFF;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_model(input string tag);
        logic [31:0] a, e;
        a = {9'd0, strobe, warp, slice, mask};
        e = {9'd0, m_strobe, (m_strobe ? IDW'(m_warp) : warp), (m_strobe ? SLW'(m_slice) : slice), model_mask()};
        check(a == e, tag, a, e);
    endtask

    // one clock: inputs held across the rising edge, outputs sampled at the falling edge
    task automatic step(input string tag);
        @(negedge clk);
        model_tick();
        compare_model(tag);
    endtask

    task automatic expect_issue(input string tag, input int w, input int s, input logic [15:0] mk);
        check(strobe && warp == IDW'(w) && slice == SLW'(s) && mask == mk, tag,
              {strobe, 7'd0, 4'(warp), 2'd0, slice, mask}, {1'b1, 7'd0, 4'(w), 2'd0, 2'(s), mk});
    endtask

    task automatic expect_idle(input string tag);
        check(!strobe && mask == 16'h0, tag, {15'd0, strobe, mask}, 32'd0);
    endtask

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        expect_idle("R1 reset outputs");
        rst = 1'b0;
        step("R1 first cycle after reset");
        expect_idle("R1 first cycle idle");

        // full rotation, single precision
        valid = '1; ready = '1; cls = '0;
        for (int k = 0; k < 2*NW; k++) begin
            step("R5 rotation");
            expect_issue("R5 R4 R3 rotation order", k/2, k%2, 16'hFFFF);
        end

        // lone double-precision warp, wraps back to itself
        valid = 16'h0020; ready = 16'h0020; cls = '0; cls[11:10] = 2'd1;
        for (int k = 0; k < 8; k++) begin
            step("R3 wide dispatch");
            expect_issue("R3 R4 four slices", 5, k%4, 16'h00FF);
        end

        // nothing eligible: pointer must stay after warp 5
        valid = '0;
        for (int k = 0; k < 4; k++) begin
            step("R6 idle");
            expect_idle("R6 idle strobe low");
        end
        valid = 16'h0208; ready = 16'h0208; cls = '0;
        step("R6 pointer kept");
        expect_issue("R6 pointer resumes after 5", 9, 0, 16'hFFFF);
        step("R4 second slice");
        step("R5 wrap to lower warp");
        expect_issue("R5 next after 9 is 3", 3, 0, 16'hFFFF);
        step("R4 tail");

        // load on warp 2 stalls it
        valid = 16'h0004; ready = 16'h0004; cls = '0; cls[5:4] = 2'd2;
        step("R7 load slice0");
        expect_issue("R7 load slice0", 2, 0, 16'hFFFF);
        step("R7 load slice1");
        for (int k = 0; k < 5; k++) begin
            step("R7 waiting");
            expect_idle("R7 warp skipped while waiting");
        end
        mdone = 1'b1; mid = 4'd2;
        step("R8 completion edge");
        expect_idle("R8 not yet eligible");
        mdone = 1'b0;
        step("R8 reissue");
        expect_issue("R8 issued after completion", 2, 0, 16'hFFFF);
        step("R7 load slice1 again");
        mdone = 1'b1;
        step("R8 clear");
        mdone = 1'b0;
        step("R8 load slice0");
        mdone = 1'b1;
        step("R8 final slice with completion");
        expect_issue("R8 final slice", 2, 1, 16'hFFFF);
        mdone = 1'b0;
        step("R8 completion wins");
        expect_issue("R8 same-edge completion wins", 2, 0, 16'hFFFF);
        step("R7 tail");

        // input changes mid-dispatch
        valid = 16'h0080; ready = 16'h0080; cls = '0; cls[15:14] = 2'd1;
        step("R9 start");
        expect_issue("R9 start", 7, 0, 16'h00FF);
        valid = '0; ready = '0; cls = '0;
        for (int k = 1; k < 4; k++) begin
            step("R9 hold");
            expect_issue("R9 slices unaffected", 7, k, 16'h00FF);
        end

        // pseudo-random sweep against the model
        lfsr = 32'hACE1_2B57;
        for (int k = 0; k < 4000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            valid = lfsr[15:0] | lfsr[31:16];
            ready = lfsr[23:8] ^ {lfsr[7:0], lfsr[31:24]};
            cls   = {lfsr, lfsr[0]} [31:0] ^ {lfsr[15:0], lfsr[31:16]};
            mdone = lfsr[3] | lfsr[9];
            mid   = lfsr[13:10];
            step("R2 sweep");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule